// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block is a real-time clock core. Its registers take up the eight highest byte addresses of a small byte-wide memory space, which uses static-RAM-style strobes. It counts seconds, minutes, hours, day of week, date, month, year and century, all in packed BCD, and advances by one second on each single-cycle `tick` pulse. Every address below the clock window reaches a plain internal byte RAM.

Software takes a stable snapshot of the time by setting a read-hold bit. While that bit is set, the visible registers stay frozen and the counters keep running underneath. To set the clock, software raises a write-hold bit, which halts counting, then writes the new fields. When the write-hold bit clears, the new values transfer into the counters. A stop bit in the seconds location pauses timekeeping until it is cleared.

The bus strobes are active-low and are assumed to be synchronous to `clk`. Each access takes one clock cycle. Read data appears on `rdata` after the clock edge that samples the read.

Top module: `rtc_bank`

## Requirements
- R1: With `W = 2**ADDR_W`, the clock window is addresses W-8 to W-1. Offsets 0 to 7 hold, in order: control/century, seconds, minutes, hour, day of week, date, month, year. After reset the bank reads century 20, time 00:00:00, day 1, date 01, month 01, year 00.
- R2: Every time field is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. A units digit of 9 carries into the tens digit (for example, hour 09 becomes 10).
- R3: On each tick the fields roll over in cascade. Seconds 59 becomes 00, minutes 59 becomes 00, hour 23 becomes 00, day 7 becomes 1, month 12 becomes 01, year 99 becomes 00, and each rollover carries into the next field. A year rollover increments the century (00-39). A date rollover carries into the month, and each day rollover also advances the day of week.
- R4: The last date of a month is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11. February ends on 29 when the year value is divisible by four (including 00) and on 28 otherwise.
- R5: Bit 7 of the seconds location is a stop bit. It can be written at any time. While it is 1, ticks do not advance any field, and it reads back in bit 7 of seconds.
- R6: Bit 7 of the control location is the write-hold bit. While it is 1, ticks are ignored and writes to the time fields (including the century in control bits 5:0) are held. The control write that clears the bit captures its century field, and all held values then load into the counters.
- R7: While the write-hold bit is 0, a write to any time field leaves that field unchanged. Only the status bits (stop, frequency test, and the two hold bits) take effect.
- R8: Bit 6 of the control location is the read-hold bit. While it is 1, reads of the time fields return the values present when it was set, and counting continues. After it clears, reads show the advanced time.
- R9: In the day location, bit 7 always reads 1 (supply good) and ignores writes. Bit 6 is a frequency-test bit that can be written at any time and reads back as written.
- R10: Bits outside each field read as 0, whatever was written to them. The field widths are: seconds 6:0, minutes 6:0, hour 5:0, day 2:0, date 5:0, month 4:0, year 7:0, century 5:0.
- R11: A write occurs when `cs_n` and `we_n` are both low, whatever `oe_n` is. A read occurs when `cs_n` and `oe_n` are low and `we_n` is high. In any cycle without a read, the next `rdata` is 0x00.
- R12: Addresses below W-8 read and write an internal byte RAM. Accesses there do not change the clock registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, 0 when not reading |

## Verification
A wrong carry or compare in the counter chain does not show at the ports until the next tick that reaches the faulty field. It then shows after one more cycle, when the visible copy follows the counters. For this reason, the time is always loaded just short of each boundary: a minute, a day, a year, and the end of each length of month. Faults in the hold logic show within two cycles of the control write that clears a hold bit: stale or altered values appear at the first read of seconds or of the century. A wrong address decode shows in the read-back of the RAM or of the clock byte at the next read.

// File: rtl/rtc_pkg.sv
// Shared constants, types and helper functions for the BCD clock bank.
// Assumes the register window is eight bytes and every field is packed BCD.
package rtc_pkg;

    localparam int NUM_REGS = 8;

    // Register offsets inside the window (the cascade order depends on them)
    localparam int IX_CTRL = 0;
    localparam int IX_SEC  = 1;
    localparam int IX_MIN  = 2;
    localparam int IX_HOUR = 3;
    localparam int IX_DAY  = 4;
    localparam int IX_DATE = 5;
    localparam int IX_MON  = 6;
    localparam int IX_YEAR = 7;

    typedef logic [NUM_REGS-1:0][7:0] reg_bank_t;

    // Packed-BCD increment without range check
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Bits that belong to the time value of each field
    function automatic logic [7:0] field_mask(input int idx);
        case (idx)
            IX_CTRL: return 8'h3F;
            IX_SEC:  return 8'h7F;
            IX_MIN:  return 8'h7F;
            IX_HOUR: return 8'h3F;
            IX_DAY:  return 8'h07;
            IX_DATE: return 8'h3F;
            IX_MON:  return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    // Value a field returns to after its rollover
    function automatic logic [7:0] field_min(input int idx);
        case (idx)
            IX_DAY, IX_DATE, IX_MON: return 8'h01;
            default:                 return 8'h00;
        endcase
    endfunction

    // Last value of each field (date is replaced by the month table)
    function automatic logic [7:0] field_max(input int idx);
        case (idx)
            IX_CTRL: return 8'h39;
            IX_SEC:  return 8'h59;
            IX_MIN:  return 8'h59;
            IX_HOUR: return 8'h23;
            IX_DAY:  return 8'h07;
            IX_DATE: return 8'h31;
            IX_MON:  return 8'h12;
            default: return 8'h99;
        endcase
    endfunction

    // Value after reset
    function automatic logic [7:0] field_reset(input int idx);
        case (idx)
            IX_CTRL:                 return 8'h20;
            IX_DAY, IX_DATE, IX_MON: return 8'h01;
            default:                 return 8'h00;
        endcase
    endfunction

    // Last date of a month in BCD, year divisible by four is a leap year
    function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] year);
        logic [7:0] yb;
        yb = ({4'd0, year[7:4]} * 8'd10) + {4'd0, year[3:0]};
        case (mon)
            8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
// One packed-BCD counter field with load, increment and wrap to a minimum.
// Assumes load and inc are never asserted together by the owner.
module rtc_bcd_field
    import rtc_pkg::*;
#(
    parameter logic [7:0] MIN_VAL   = 8'h00,
    parameter logic [7:0] RESET_VAL = 8'h00,
    parameter logic [7:0] MASK      = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic [7:0] max_val,
    output logic [7:0] val,
    output logic       wrap
);

    logic [7:0] val_q;

    assign val  = val_q;
    assign wrap = inc && (val_q >= max_val);

    // Field register: reset, software load, or BCD step with rollover
    always_ff @(posedge clk) begin
        if (!rst_n)    val_q <= RESET_VAL;
        else if (load) val_q <= load_val & MASK;
        else if (inc)  val_q <= wrap ? MIN_VAL : (bcd_inc(val_q) & MASK);
    end

    // Rollover lands on the field's minimum (R3)
    assert_wrap_to_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !load) |=> (val_q == MIN_VAL));

    // A step from valid BCD keeps the units digit decimal (R2)
    assert_bcd_units_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && val_q[3:0] <= 4'd9 && val_q[7:4] <= 4'd9) |=> (val_q[3:0] <= 4'd9));

endmodule

// File: rtl/rtc_chain.sv
// The cascade of eight BCD fields: seconds up to century.
// Assumes adv is a single-cycle advance request and load is exclusive with it.
module rtc_chain
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      load,
    input  reg_bank_t load_vals,
    output reg_bank_t vals
);

    logic [NUM_REGS-1:0] inc_v;
    logic [NUM_REGS-1:0] wrap_v;
    reg_bank_t           max_v;
    logic                unused_wraps;

    assign unused_wraps = wrap_v[IX_CTRL] ^ wrap_v[IX_DAY];

    // Carry network: each field steps on the rollover of the one below it
    always_comb begin
        inc_v          = '0;
        inc_v[IX_SEC]  = adv;
        inc_v[IX_MIN]  = wrap_v[IX_SEC];
        inc_v[IX_HOUR] = wrap_v[IX_MIN];
        inc_v[IX_DAY]  = wrap_v[IX_HOUR];
        inc_v[IX_DATE] = wrap_v[IX_HOUR];
        inc_v[IX_MON]  = wrap_v[IX_DATE];
        inc_v[IX_YEAR] = wrap_v[IX_MON];
        inc_v[IX_CTRL] = wrap_v[IX_YEAR];
    end

    // One field per register slot; the date limit comes from the month table
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_field
        if (i == IX_DATE) begin : g_date_max
            assign max_v[i] = month_days(vals[IX_MON], vals[IX_YEAR]);
        end else begin : g_fixed_max
            assign max_v[i] = field_max(i);
        end

        rtc_bcd_field #(
            .MIN_VAL  (field_min(i)),
            .RESET_VAL(field_reset(i)),
            .MASK     (field_mask(i))
        ) i_field (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (inc_v[i]),
            .load    (load),
            .load_val(load_vals[i]),
            .max_val (max_v[i]),
            .val     (vals[i]),
            .wrap    (wrap_v[i])
        );
    end

    // Without an advance or a load nothing moves (R5, R6)
    assert_no_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(vals));

    // A stepped date stays within 01..31 (R4)
    assert_date_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_v[IX_DATE] && !load) |=> (vals[IX_DATE] != 8'h00 && vals[IX_DATE] <= 8'h31));

endmodule

// File: rtl/rtc_byte_ram.sv
// Plain byte RAM for the space under the clock window.
// Assumes callers only write addresses below DEPTH; reads above return zero.
module rtc_byte_ram #(
    parameter int ADDR_W = 6,
    parameter int DEPTH  = 56
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    logic [7:0] mem [DEPTH];

    // Store a byte on a write strobe
    always_ff @(posedge clk) begin
        if (we && (int'(addr) < DEPTH)) mem[addr] <= wdata;
    end

    // Asynchronous read, owner registers the result
    always_comb begin
        rdata = (int'(addr) < DEPTH) ? mem[addr] : 8'h00;
    end

endmodule

// File: rtl/rtc_bank.sv
// Top of the BCD clock bank: bus decode, hold bits, visible copy and RAM.
// Assumes bus strobes are synchronous to clk and tick is one cycle wide.
module rtc_bank
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    localparam int              RAM_DEPTH = (2 ** ADDR_W) - NUM_REGS;
    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(RAM_DEPTH);

    logic       wr_cyc, rd_cyc, in_win;
    logic [2:0] sel;
    logic       w_bit, r_bit, stop_bit, ft_bit, load_pend;
    logic       adv;
    reg_bank_t  cnt, hold_q;
    logic [7:0] view, ram_rd, rdata_q;

    assign wr_cyc = !cs_n && !we_n;
    assign rd_cyc = !cs_n && !oe_n && we_n;
    assign in_win = (addr >= WIN_BASE);
    assign sel    = addr[2:0];
    assign adv    = tick && !w_bit && !stop_bit && !load_pend;
    assign rdata  = rdata_q;

    // Status bits: holds, stop and frequency test; flag a transfer on write-hold release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_bit     <= 1'b0;
            r_bit     <= 1'b0;
            stop_bit  <= 1'b0;
            ft_bit    <= 1'b0;
            load_pend <= 1'b0;
        end else begin
            load_pend <= 1'b0;
            if (wr_cyc && in_win) begin
                case (int'(sel))
                    IX_CTRL: begin
                        w_bit     <= wdata[7];
                        r_bit     <= wdata[6];
                        load_pend <= w_bit && !wdata[7];
                    end
                    IX_SEC:  stop_bit <= wdata[7];
                    IX_DAY:  ft_bit   <= wdata[6];
                    default: ;
                endcase
            end
        end
    end

    // Visible copy: takes held writes, otherwise follows the counters unless frozen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) hold_q[i] <= field_reset(i);
        end else if (wr_cyc && in_win && w_bit) begin
            hold_q[sel] <= wdata & field_mask(int'(sel));
        end else if (!r_bit && !w_bit && !load_pend) begin
            hold_q <= cnt;
        end
    end

    rtc_chain i_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .load     (load_pend),
        .load_vals(hold_q),
        .vals     (cnt)
    );

    rtc_byte_ram #(
        .ADDR_W(ADDR_W),
        .DEPTH (RAM_DEPTH)
    ) i_ram (
        .clk  (clk),
        .we   (wr_cyc && !in_win),
        .addr (addr),
        .wdata(wdata),
        .rdata(ram_rd)
    );

    // Read view of the window with the status bits merged in
    always_comb begin
        case (int'(sel))
            IX_CTRL: view = {w_bit, r_bit, hold_q[IX_CTRL][5:0]};
            IX_SEC:  view = {stop_bit, hold_q[IX_SEC][6:0]};
            IX_DAY:  view = {1'b1, ft_bit, 3'b000, hold_q[IX_DAY][2:0]};
            default: view = hold_q[sel];
        endcase
    end

    // Registered read data, zero outside read cycles
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= 8'h00;
        else if (rd_cyc) rdata_q <= in_win ? view : ram_rd;
        else             rdata_q <= 8'h00;
    end

    // Read-hold keeps the visible copy still while write-hold is off (R8)
    assert_snapshot_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_bit && !w_bit) |=> $stable(hold_q));

endmodule

// File: tb/test_rtc_bank.sv
module test_rtc_bank;

    localparam int ADDR_W = 6;
    localparam int BASE   = (2 ** ADDR_W) - 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              cs_n = 1'b1;
    logic              oe_n = 1'b1;
    logic              we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    rtc_bank #(.ADDR_W(ADDR_W)) i_rtc_bank (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cs_n(cs_n), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d, input logic oe = 1'b1);
        cs_n = 1'b0; we_n = 1'b0; oe_n = oe; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd_chk(input int a, input logic [7:0] exp, input string tag);
        cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = ADDR_W'(a);
        @(negedge clk);
        check(rdata, exp, tag);
        cs_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] c, y, mo, dt, dy, h, mi, s);
        wr(BASE + 0, 8'h80);
        wr(BASE + 7, y);  wr(BASE + 6, mo); wr(BASE + 5, dt); wr(BASE + 4, dy);
        wr(BASE + 3, h);  wr(BASE + 2, mi); wr(BASE + 1, s);
        wr(BASE + 0, c);
    endtask

    task automatic t_reset();
        rd_chk(BASE + 0, 8'h20, "R1 reset century");
        rd_chk(BASE + 1, 8'h00, "R1 reset seconds");
        rd_chk(BASE + 2, 8'h00, "R1 reset minutes");
        rd_chk(BASE + 3, 8'h00, "R1 reset hour");
        rd_chk(BASE + 4, 8'h81, "R9 reset day with supply flag");
        rd_chk(BASE + 5, 8'h01, "R1 reset date");
        rd_chk(BASE + 6, 8'h01, "R1 reset month");
        rd_chk(BASE + 7, 8'h00, "R1 reset year");
    endtask

    task automatic t_cascade();
        set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58);
        rd_chk(BASE + 1, 8'h58, "R6 loaded seconds");
        pulse(1);
        rd_chk(BASE + 1, 8'h59, "R3 seconds step");
        rd_chk(BASE + 2, 8'h59, "R3 minutes unchanged");
        pulse(1);
        rd_chk(BASE + 1, 8'h00, "R3 seconds wrap");
        rd_chk(BASE + 2, 8'h00, "R3 minutes wrap");
        rd_chk(BASE + 3, 8'h00, "R3 hour wrap");
        rd_chk(BASE + 4, 8'h81, "R3 day of week wrap");
        rd_chk(BASE + 5, 8'h01, "R3 date wrap");
        rd_chk(BASE + 6, 8'h01, "R3 month wrap");
        rd_chk(BASE + 7, 8'h00, "R3 year wrap");
        rd_chk(BASE + 0, 8'h21, "R3 century step");
        set_time(8'h20, 8'h10, 8'h03, 8'h15, 8'h02, 8'h09, 8'h59, 8'h59);
        pulse(1);
        rd_chk(BASE + 3, 8'h10, "R2 hour tens carry");
        rd_chk(BASE + 4, 8'h82, "R3 day unchanged mid-day");
    endtask

    task automatic t_months();
        set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        pulse(1);
        rd_chk(BASE + 5, 8'h29, "R4 leap Feb 28 to 29");
        rd_chk(BASE + 4, 8'h84, "R3 day advances with date");
        set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
        pulse(1);
        rd_chk(BASE + 5, 8'h01, "R4 leap Feb 29 wrap");
        rd_chk(BASE + 6, 8'h03, "R4 leap month to March");
        set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        pulse(1);
        rd_chk(BASE + 6, 8'h03, "R4 common Feb 28 wrap");
        set_time(8'h20, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        pulse(1);
        rd_chk(BASE + 5, 8'h29, "R4 year 00 is leap");
        set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
        pulse(1);
        rd_chk(BASE + 6, 8'h05, "R4 April 30 wrap");
        set_time(8'h20, 8'h23, 8'h08, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
        pulse(1);
        rd_chk(BASE + 5, 8'h31, "R4 August has 31");
    endtask

    task automatic t_write_hold();
        set_time(8'h20, 8'h30, 8'h06, 8'h10, 8'h03, 8'h08, 8'h15, 8'h20);
        wr(BASE + 0, 8'h80);
        pulse(2);
        rd_chk(BASE + 1, 8'h20, "R6 frozen while write-hold");
        wr(BASE + 1, 8'h45);
        wr(BASE + 0, 8'h35);
        rd_chk(BASE + 1, 8'h45, "R6 held seconds transferred");
        rd_chk(BASE + 0, 8'h35, "R6 century captured on release");
        rd_chk(BASE + 2, 8'h15, "R6 minutes kept, no ticks counted");
    endtask

    task automatic t_stop_and_ignore();
        set_time(8'h20, 8'h30, 8'h06, 8'h10, 8'h03, 8'h08, 8'h15, 8'h20);
        wr(BASE + 1, 8'h87);
        rd_chk(BASE + 1, 8'hA0, "R5 stop set, R7 field ignored");
        pulse(2);
        rd_chk(BASE + 1, 8'hA0, "R5 no advance while stopped");
        wr(BASE + 1, 8'h00);
        pulse(1);
        rd_chk(BASE + 1, 8'h21, "R5 runs after stop clears");
        wr(BASE + 2, 8'h33);
        rd_chk(BASE + 2, 8'h15, "R7 minutes write ignored");
    endtask

    task automatic t_read_hold();
        set_time(8'h20, 8'h24, 8'h05, 8'h10, 8'h05, 8'h12, 8'h30, 8'h10);
        wr(BASE + 0, 8'h4A);
        pulse(3);
        rd_chk(BASE + 1, 8'h10, "R8 snapshot seconds");
        rd_chk(BASE + 0, 8'h60, "R8 read-hold visible, R7 century ignored");
        wr(BASE + 0, 8'h00);
        rd_chk(BASE + 1, 8'h13, "R8 counting continued under snapshot");
    endtask

    task automatic t_status_bits();
        set_time(8'h20, 8'h24, 8'h05, 8'h10, 8'h05, 8'h12, 8'h30, 8'h10);
        wr(BASE + 4, 8'h42);
        rd_chk(BASE + 4, 8'hC5, "R9 frequency-test set, supply flag 1");
        wr(BASE + 4, 8'h00);
        rd_chk(BASE + 4, 8'h85, "R9 frequency-test cleared");
        wr(BASE + 0, 8'h80);
        wr(BASE + 6, 8'hE1);
        wr(BASE + 3, 8'hC5);
        wr(BASE + 2, 8'hC7);
        wr(BASE + 0, 8'h20);
        rd_chk(BASE + 6, 8'h01, "R10 month unused bits zero");
        rd_chk(BASE + 3, 8'h05, "R10 hour unused bits zero");
        rd_chk(BASE + 2, 8'h47, "R10 minutes bit 7 zero");
    endtask

    task automatic t_bus_and_ram();
        cs_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; addr = ADDR_W'(BASE + 0);
        @(negedge clk);
        check(rdata, 8'h00, "R11 no read without chip select");
        cs_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        check(rdata, 8'h00, "R11 no read without output enable");
        cs_n = 1'b1;
        wr(3, 8'hA5, 1'b0);
        rd_chk(3, 8'hA5, "R11 write wins with output enable low");
        wr(0, 8'h11);
        wr(BASE - 1, 8'h77);
        rd_chk(0, 8'h11, "R12 RAM low byte");
        rd_chk(BASE - 1, 8'h77, "R12 RAM top byte");
        rd_chk(BASE + 6, 8'h01, "R12 clock untouched by RAM writes");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cascade();
        t_months();
        t_write_hold();
        t_stop_and_ignore();
        t_read_hold();
        t_status_bits();
        t_bus_and_ram();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule